// File: doc/BRIEF.md
# Multi-Circuit Runtime Powering Interlock

This block is the runtime protection core of a powering interlock controller that serves several superconducting magnet circuits in one powering subsector. Every circuit carries a configured interlock class, and that class decides which of its signal loops take part: the converter failure loop and the permit line always do, the circuit-quench loop and fast-abort line appear from the middle classes upward, and the coolant-loss loop and discharge-request line exist only in the top class. Four subsector-wide conditions (UPS health, emergency stop, cryogenic maintain and quench propagation) act on every circuit at once.

All loop signals are fail-safe: a 1 means healthy or no action, a 0 means fault or action requested. Every input, the per-circuit unlatch commands included, passes a two-flop synchronizer. Any trip is latched per circuit. It is released only by that circuit's unlatch command, and only once no cause remains. A sticky first-fault code per circuit records what tripped it first.

Top module: `circuit_ilk_core`

## Requirements
- R1: After reset every permit output is 0, every fast-abort, slow-abort and discharge output is 1 (inactive), and every fault code is 0.
- R2: Class encoding is 0 = lowest, 1 = middle A, 2 = middle B, 3 = highest. An unlatch with no cause present raises the permit on the line for the circuit's class: `permitMain` for classes 0 and 3, `permitMidA` for class 1, `permitMidB` for class 2. The other two lines stay 0 for that circuit.
- R3: A dropped permit stays 0 after its cause clears, until an unlatch is applied.
- R4: A powering-failure input at 0 drops that circuit's permit and records fault code 6.
- R5: A circuit-quench input at 0 on a class 1, 2 or 3 circuit latches its fast-abort output to 0 and records code 4. On a class 0 circuit the quench input has no effect.
- R6: UPS OK or emergency-stop OK at 0 drops every permit, latches fast-abort to 0 on every class 1 to 3 circuit, and records code 1 (UPS) or 2 (emergency stop).
- R7: Quench-propagation OK at 0 does the same to every circuit and records code 3.
- R8: Cryo-maintain OK at 0 drops every permit and latches slow-abort to 0 on every circuit, with no fast abort. It records code 7.
- R9: Coolant-loss input at 0 on a class 3 circuit latches discharge-request to 0 and records code 5. On other classes it has no effect.
- R10: When fast and slow abort are both latched on a circuit that has a fast-abort line, only fast-abort is driven to 0.
- R11: Unlatch is ignored while any cause for that circuit is still present.
- R12: The fault code holds the first cause seen after the last unlatch and is not overwritten by later causes. When several causes appear in one cycle, the lowest non-zero code wins. Unlatch clears the code to 0.
- R13: A change at an input shows at the outputs after three rising clock edges: two synchronizer stages and one latch stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| circClass | input | 2*N_CIRC | Static class per circuit, 2 bits each |
| pwrOkIn | input | N_CIRC | Converter healthy per circuit (0 = powering failure) |
| quenchOkIn | input | N_CIRC | Circuit-quench loop closed per circuit (0 = quench) |
| coolOkIn | input | N_CIRC | Coolant present per circuit (0 = coolant loss) |
| unlatchIn | input | N_CIRC | Unlatch command per circuit, active high |
| upsOkIn | input | 1 | UPS healthy, subsector-wide |
| estopOkIn | input | 1 | Emergency-stop chain healthy, subsector-wide |
| cryoOkIn | input | 1 | Cryo-maintain present, subsector-wide |
| qpropOkIn | input | 1 | No quench propagation, subsector-wide |
| permitMain | output | N_CIRC | Permit for class 0 and 3 circuits |
| permitMidA | output | N_CIRC | Permit for class 1 circuits |
| permitMidB | output | N_CIRC | Permit for class 2 circuits |
| fastAbortN | output | N_CIRC | Fast-abort request, 0 = abort |
| slowAbortN | output | N_CIRC | Slow-abort request, 0 = abort |
| dischargeN | output | N_CIRC | Discharge request, 0 = discharge |
| faultCode | output | 3*N_CIRC | First-fault code per circuit |

## Verification
The assertions assume that the class configuration is static while out of reset. They also assume that unlatch is a level command that the synchronizer resamples every cycle. The stimulus sets `circClass` once before reset is released and never changes it afterwards. It holds each input change for at least three clock cycles, so that every change passes both synchronizer stages before it is judged. Trips are provoked one cause at a time and also in overlapping pairs, which covers the abort priority and the first-fault ordering.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    CLS_LOW  = 2'd0,
    CLS_MIDA = 2'd1,
    CLS_MIDB = 2'd2,
    CLS_HIGH = 2'd3
  } circ_class_e;

  // Lower value wins when several causes arrive together
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_UPS     = 3'd1,
    CAUSE_ESTOP   = 3'd2,
    CAUSE_QPROP   = 3'd3,
    CAUSE_QUENCH  = 3'd4,
    CAUSE_COOLANT = 3'd5,
    CAUSE_PWRFAIL = 3'd6,
    CAUSE_CRYO    = 3'd7
  } cause_e;

  typedef struct packed {
    logic   tripPermit;
    logic   tripFast;
    logic   tripSlow;
    logic   tripDisch;
    logic   unlatch;
    cause_e cause;
  } ilk_strobe_t;

endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= {WIDTH{RST_BIT}};
      dOut   <= {WIDTH{RST_BIT}};
    end else begin
      stage1 <= dIn;
      dOut   <= stage1;
    end
  end
endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int N_CIRC = 4
) (
  input  logic [2*N_CIRC-1:0] circClass,
  input  logic [N_CIRC-1:0]   pwrOk,
  input  logic [N_CIRC-1:0]   quenchOk,
  input  logic [N_CIRC-1:0]   coolOk,
  input  logic [N_CIRC-1:0]   unlatchReq,
  input  logic                upsOk,
  input  logic                estopOk,
  input  logic                cryoOk,
  input  logic                qpropOk,
  output ilk_strobe_t         strobes [N_CIRC]
);
  logic globalFast;
  logic globalSlow;

  assign globalFast = !upsOk || !estopOk || !qpropOk;
  assign globalSlow = !cryoOk;

  for (genvar i = 0; i < N_CIRC; i++) begin : g_circ
    circ_class_e cls;
    logic pfCause, qCause, clCause, anyCause;

    assign cls      = circ_class_e'(circClass[2*i +: 2]);
    assign pfCause  = !pwrOk[i];
    assign qCause   = (cls != CLS_LOW) && !quenchOk[i];
    assign clCause  = (cls == CLS_HIGH) && !coolOk[i];
    assign anyCause = pfCause || qCause || clCause || globalFast || globalSlow;

    always_comb begin
      strobes[i].tripPermit = anyCause;
      strobes[i].tripFast   = (cls != CLS_LOW) && (qCause || globalFast);
      strobes[i].tripSlow   = globalSlow;
      strobes[i].tripDisch  = clCause;
      strobes[i].unlatch    = unlatchReq[i] && !anyCause;
      if (!upsOk)        strobes[i].cause = CAUSE_UPS;
      else if (!estopOk) strobes[i].cause = CAUSE_ESTOP;
      else if (!qpropOk) strobes[i].cause = CAUSE_QPROP;
      else if (qCause)   strobes[i].cause = CAUSE_QUENCH;
      else if (clCause)  strobes[i].cause = CAUSE_COOLANT;
      else if (pfCause)  strobes[i].cause = CAUSE_PWRFAIL;
      else if (!cryoOk)  strobes[i].cause = CAUSE_CRYO;
      else               strobes[i].cause = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/ilk_datapath.sv
module ilk_datapath
  import ilk_pkg::*;
#(
  parameter int N_CIRC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*N_CIRC-1:0] circClass,
  input  ilk_strobe_t         strobes [N_CIRC],
  output logic [N_CIRC-1:0]   permitMain,
  output logic [N_CIRC-1:0]   permitMidA,
  output logic [N_CIRC-1:0]   permitMidB,
  output logic [N_CIRC-1:0]   fastAbortN,
  output logic [N_CIRC-1:0]   slowAbortN,
  output logic [N_CIRC-1:0]   dischargeN,
  output logic [3*N_CIRC-1:0] faultCode
);
  logic [N_CIRC-1:0] permitLost;
  logic [N_CIRC-1:0] fastLat;
  logic [N_CIRC-1:0] slowLat;
  logic [N_CIRC-1:0] dischLat;
  cause_e            causeReg [N_CIRC];

  for (genvar i = 0; i < N_CIRC; i++) begin : g_circ
    circ_class_e cls;
    assign cls = circ_class_e'(circClass[2*i +: 2]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        permitLost[i] <= 1'b1;
        fastLat[i]    <= 1'b0;
        slowLat[i]    <= 1'b0;
        dischLat[i]   <= 1'b0;
        causeReg[i]   <= CAUSE_NONE;
      end else if (strobes[i].unlatch) begin
        permitLost[i] <= 1'b0;
        fastLat[i]    <= 1'b0;
        slowLat[i]    <= 1'b0;
        dischLat[i]   <= 1'b0;
        causeReg[i]   <= CAUSE_NONE;
      end else begin
        permitLost[i] <= permitLost[i] | strobes[i].tripPermit;
        fastLat[i]    <= fastLat[i]    | strobes[i].tripFast;
        slowLat[i]    <= slowLat[i]    | strobes[i].tripSlow;
        dischLat[i]   <= dischLat[i]   | strobes[i].tripDisch;
        if (causeReg[i] == CAUSE_NONE && strobes[i].tripPermit)
          causeReg[i] <= strobes[i].cause;
      end
    end

    always_comb begin
      permitMain[i] = !permitLost[i] && (cls == CLS_LOW || cls == CLS_HIGH);
      permitMidA[i] = !permitLost[i] && (cls == CLS_MIDA);
      permitMidB[i] = !permitLost[i] && (cls == CLS_MIDB);
      fastAbortN[i] = !(fastLat[i] && cls != CLS_LOW);
      slowAbortN[i] = !(slowLat[i] && fastAbortN[i]);
      dischargeN[i] = !(dischLat[i] && cls == CLS_HIGH);
      faultCode[3*i +: 3] = causeReg[i];
    end

    p_permit_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
      permitLost[i] && !strobes[i].unlatch |=> permitLost[i]);

    p_trip_drops_permit_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].tripPermit |=> !(permitMain[i] || permitMidA[i] || permitMidB[i]));

    p_disch_high_only_r9: assert property (@(posedge clk) disable iff (!rstN)
      !dischargeN[i] |-> cls == CLS_HIGH);

    p_fast_over_slow_r10: assert property (@(posedge clk) disable iff (!rstN)
      fastLat[i] && cls != CLS_LOW |-> slowAbortN[i]);

    p_cause_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
      causeReg[i] != CAUSE_NONE && !strobes[i].unlatch |=> $stable(causeReg[i]));
  end
endmodule

// File: rtl/circuit_ilk_core.sv
module circuit_ilk_core
  import ilk_pkg::*;
#(
  parameter int N_CIRC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*N_CIRC-1:0] circClass,
  input  logic [N_CIRC-1:0]   pwrOkIn,
  input  logic [N_CIRC-1:0]   quenchOkIn,
  input  logic [N_CIRC-1:0]   coolOkIn,
  input  logic [N_CIRC-1:0]   unlatchIn,
  input  logic                upsOkIn,
  input  logic                estopOkIn,
  input  logic                cryoOkIn,
  input  logic                qpropOkIn,
  output logic [N_CIRC-1:0]   permitMain,
  output logic [N_CIRC-1:0]   permitMidA,
  output logic [N_CIRC-1:0]   permitMidB,
  output logic [N_CIRC-1:0]   fastAbortN,
  output logic [N_CIRC-1:0]   slowAbortN,
  output logic [N_CIRC-1:0]   dischargeN,
  output logic [3*N_CIRC-1:0] faultCode
);
  localparam int OK_W = 3 * N_CIRC + 4;

  logic [OK_W-1:0]   okRaw, okSync;
  logic [N_CIRC-1:0] unlatchSync;
  ilk_strobe_t       strobes [N_CIRC];

  assign okRaw = {qpropOkIn, cryoOkIn, estopOkIn, upsOkIn, coolOkIn, quenchOkIn, pwrOkIn};

  ilk_sync #(.WIDTH(OK_W), .RST_BIT(1'b1)) u_okSync (
    .clk(clk), .rstN(rstN), .dIn(okRaw), .dOut(okSync));

  ilk_sync #(.WIDTH(N_CIRC), .RST_BIT(1'b0)) u_unlatchSync (
    .clk(clk), .rstN(rstN), .dIn(unlatchIn), .dOut(unlatchSync));

  ilk_ctrl #(.N_CIRC(N_CIRC)) u_ctrl (
    .circClass (circClass),
    .pwrOk     (okSync[N_CIRC-1:0]),
    .quenchOk  (okSync[2*N_CIRC-1:N_CIRC]),
    .coolOk    (okSync[3*N_CIRC-1:2*N_CIRC]),
    .unlatchReq(unlatchSync),
    .upsOk     (okSync[3*N_CIRC]),
    .estopOk   (okSync[3*N_CIRC+1]),
    .cryoOk    (okSync[3*N_CIRC+2]),
    .qpropOk   (okSync[3*N_CIRC+3]),
    .strobes   (strobes));

  ilk_datapath #(.N_CIRC(N_CIRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .circClass (circClass),
    .strobes   (strobes),
    .permitMain(permitMain),
    .permitMidA(permitMidA),
    .permitMidB(permitMidB),
    .fastAbortN(fastAbortN),
    .slowAbortN(slowAbortN),
    .dischargeN(dischargeN),
    .faultCode (faultCode));
endmodule

// File: tb/circuit_ilk_core_test.sv
module circuit_ilk_core_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2*N-1:0] circClass = 8'b11_10_01_00; // circuit i has class i
  logic [N-1:0] pwrOkIn = '1, quenchOkIn = '1, coolOkIn = '1, unlatchIn = '0;
  logic upsOkIn = 1'b1, estopOkIn = 1'b1, cryoOkIn = 1'b1, qpropOkIn = 1'b1;
  logic [N-1:0] permitMain, permitMidA, permitMidB, fastAbortN, slowAbortN, dischargeN;
  logic [3*N-1:0] faultCode;

  always #5 clk = ~clk;

  circuit_ilk_core #(.N_CIRC(N)) uut (.*);

  typedef struct {
    string       tag;
    int          sel;
    logic [11:0] exp;
  } item_t;

  item_t expQ[$];
  event  chk;
  int    checks = 0, errors = 0;
  bit    done = 0;

  localparam int S_MAIN = 0, S_MIDA = 1, S_MIDB = 2, S_FAST = 3, S_SLOW = 4, S_DISCH = 5, S_CODE = 6;

  function automatic logic [11:0] observe(int sel);
    case (sel)
      S_MAIN:  return {8'h0, permitMain};
      S_MIDA:  return {8'h0, permitMidA};
      S_MIDB:  return {8'h0, permitMidB};
      S_FAST:  return {8'h0, fastAbortN};
      S_SLOW:  return {8'h0, slowAbortN};
      S_DISCH: return {8'h0, dischargeN};
      default: return faultCode;
    endcase
  endfunction

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(chk);
      while (expQ.size() > 0) begin
        item_t it;
        logic [11:0] got;
        it  = expQ.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic push(string tag, int sel, logic [11:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    expQ.push_back(it);
  endtask

  task automatic expectAll(string tag, logic [3:0] pm, logic [3:0] pa, logic [3:0] pb,
                           logic [3:0] fa, logic [3:0] sa, logic [3:0] di, logic [11:0] fc);
    push(tag, S_MAIN, {8'h0, pm}); push(tag, S_MIDA, {8'h0, pa});
    push(tag, S_MIDB, {8'h0, pb}); push(tag, S_FAST, {8'h0, fa});
    push(tag, S_SLOW, {8'h0, sa}); push(tag, S_DISCH, {8'h0, di});
    push(tag, S_CODE, fc);
    ->chk;
    #1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic unlatch(logic [3:0] mask);
    unlatchIn = mask; settle();
    unlatchIn = '0;   settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectAll("R1 reset", 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b1111, 12'h000);

    unlatch(4'b1111);
    expectAll("R2 permit lines", 4'b1001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h000);

    // R13: two edges after the change nothing shows, the third edge latches
    pwrOkIn[1] = 1'b0;
    repeat (2) @(negedge clk);
    push("R13 not yet", S_MIDA, 12'h002); ->chk; #1;
    @(negedge clk);
    expectAll("R4 pwr fail", 4'b1001, 4'b0000, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h030);
    unlatch(4'b0010);
    expectAll("R11 unlatch blocked", 4'b1001, 4'b0000, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h030);
    pwrOkIn[1] = 1'b1; settle(); settle();
    expectAll("R3 held after clear", 4'b1001, 4'b0000, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h030);
    unlatch(4'b0010);
    expectAll("R12 code cleared", 4'b1001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h000);

    quenchOkIn[0] = 1'b0; settle();
    expectAll("R5 class0 quench ignored", 4'b1001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h000);
    quenchOkIn[0] = 1'b1; quenchOkIn[2] = 1'b0; settle();
    expectAll("R5 quench fast abort", 4'b1001, 4'b0010, 4'b0000, 4'b1011, 4'b1111, 4'b1111, 12'h100);
    quenchOkIn[2] = 1'b1; settle();
    push("R5 fast latched", S_FAST, 12'h00B); ->chk; #1;
    unlatch(4'b0100);

    coolOkIn[1] = 1'b0; coolOkIn[3] = 1'b0; settle();
    expectAll("R9 coolant discharge", 4'b0001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b0111, 12'hA00);
    coolOkIn = '1; settle();
    unlatch(4'b1000);

    upsOkIn = 1'b0; settle();
    expectAll("R6 ups loss", 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b1111, 4'b1111, 12'h249);
    upsOkIn = 1'b1; settle(); unlatch(4'b1111);
    estopOkIn = 1'b0; settle();
    expectAll("R6 estop loss", 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b1111, 4'b1111, 12'h492);
    estopOkIn = 1'b1; settle(); unlatch(4'b1111);
    qpropOkIn = 1'b0; settle();
    expectAll("R7 quench propagation", 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b1111, 4'b1111, 12'h6DB);
    qpropOkIn = 1'b1; settle(); unlatch(4'b1111);

    cryoOkIn = 1'b0; settle();
    expectAll("R8 cryo slow abort", 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 12'hFFF);
    upsOkIn = 1'b0; settle();
    expectAll("R10 fast over slow R12 sticky", 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b1110, 4'b1111, 12'hFFF);
    upsOkIn = 1'b1; cryoOkIn = 1'b1; settle(); unlatch(4'b1111);
    expectAll("R2 restored", 4'b1001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h000);

    pwrOkIn[3] = 1'b0; quenchOkIn[3] = 1'b0; settle();
    expectAll("R12 simultaneous lowest code", 4'b0001, 4'b0010, 4'b0100, 4'b0111, 4'b1111, 4'b1111, 12'h800);
    pwrOkIn = '1; quenchOkIn = '1; settle(); unlatch(4'b1000);
    expectAll("R12 cleared on unlatch", 4'b1001, 4'b0010, 4'b0100, 4'b1111, 4'b1111, 4'b1111, 12'h000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule